// File: doc/BRIEF.md
# Indirect Test Register Bridge

This block puts a small window of host-visible management registers in front of a bank of hidden test and configuration registers. The hidden registers can each be between 1 and 32 bits wide, and they cannot be addressed directly. To reach one, the host writes a control word. That word arms test mode, picks a source slot and a target slot, and carries two command bits that clear themselves.

A read command copies the selected hidden register into a pair of 16-bit read-back words. A write command loads the selected hidden register from a pair of 16-bit staging words.

The host port is a plain register port: a 5-bit address, a write strobe, 16-bit write data and combinational read data. A command acts on the clock edge that takes the control write, and the read-back words show the result from the next cycle.

Top module: `test_reg_bridge`

## Requirements
- R1: The control word at address 20 holds the test-mode enable in bit 10, the source slot in bits 9:5 and the target slot in bits 4:0, and all of these read back as written. Bits 15:11 always read 0, including the two command bits 15 and 14.
- R2: A control write with bit 15 = 1 and bit 10 = 1 copies hidden slot [9:5] into the read-back words. Address 21 then returns bits 15:0 of that slot from the next cycle on.
- R3: After a read command, address 22 returns bits 31:16 of the slot when the slot is wider than 16 bits. For a slot of 16 bits or fewer, address 22 returns 0.
- R4: A control write with bit 14 = 1 and bit 10 = 1 loads hidden slot [4:0] with {word at 24, word at 23}, truncated to the slot's width. Both staging words at 23 and 24 can be read back as written.
- R5: A command in a control write whose bit 10 is 0 changes neither the hidden slots nor the read-back words. The command bit still reads back as 0.
- R6: When bits 15 and 14 are both 1 in one control write, the write is done first. A read of the same slot therefore returns the newly written value.
- R7: Slots at index 24 and above are absent. They ignore write commands and read back as 0 in both words.
- R8: Reset clears the control word, both staging words, both read-back words and every hidden slot. Host writes to addresses 21 and 22 have no effect. Any other address reads as 0.
- R9: Slot a, for a below 24, is ((11*a + 4) mod 32) + 1 bits wide. This gives 1 bit at slot 20, 16 bits at slot 1, 17 bits at slot 4 and 32 bits at slot 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 5 | Management register address |
| host_we | input | 1 | Write strobe for the addressed register |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the addressed register, combinational |

## Verification
The properties assume that the host changes its address, strobe and data only between clock edges. They also assume that a command's effect on the read-back words is judged in the cycle after the control write, and never in the cycle of that write.

The stimulus follows this by driving every input on the falling edge, one operation per cycle. It covers every slot index, both settings of the enable bit, combined commands and writes to the read-only addresses. A behavioural model in the bench predicts the read data for every cycle.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    localparam int HADDR_W    = 5;
    localparam int HDATA_W    = 16;
    localparam int SLOT_AW    = 5;
    localparam int SLOT_COUNT = 1 << SLOT_AW;
    localparam int SLOT_MAX_W = 2 * HDATA_W;

    // Bit positions inside the control word.
    localparam int BIT_RD_GO = 15;
    localparam int BIT_WR_GO = 14;
    localparam int BIT_TMODE = 10;

    typedef struct packed {
        logic               tmode;
        logic [SLOT_AW-1:0] src_slot;
        logic [SLOT_AW-1:0] dst_slot;
    } ctrl_t;

    typedef struct packed {
        logic               rd_go;
        logic               wr_go;
        logic [SLOT_AW-1:0] src_slot;
        logic [SLOT_AW-1:0] dst_slot;
    } cmd_t;

    // Width of hidden slot a; 0 means the slot is absent.
    function automatic int slot_width(input int a, input int impl_count);
        if (a >= impl_count || a < 0) return 0;
        return ((11 * a + 4) % 32) + 1;
    endfunction

    function automatic logic [SLOT_MAX_W-1:0] width_mask(input int w);
        if (w <= 0) return '0;
        if (w >= SLOT_MAX_W) return '1;
        return (SLOT_MAX_W'(1) << w) - SLOT_MAX_W'(1);
    endfunction

endpackage

// File: rtl/tbr_regs.sv
module tbr_regs
    import tbr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic               sel_ctrl,
    input  logic               sel_stage_lo,
    input  logic               sel_stage_hi,
    input  logic [HDATA_W-1:0] host_wdata,
    output ctrl_t              ctrl_q,
    output cmd_t               cmd,
    output logic [HDATA_W-1:0] stage_lo_q,
    output logic [HDATA_W-1:0] stage_hi_q
);

    ctrl_t ctrl_d;
    logic  ctrl_wr;
    logic  unused_rsvd;

    assign ctrl_wr     = host_we && sel_ctrl;
    assign unused_rsvd = ^host_wdata[13:11];

    always_comb begin
        ctrl_d.tmode    = host_wdata[BIT_TMODE];
        ctrl_d.src_slot = host_wdata[9:5];
        ctrl_d.dst_slot = host_wdata[4:0];
    end

    // Command pulses exist only in the cycle of the control write.
    always_comb begin
        cmd.rd_go    = ctrl_wr && host_wdata[BIT_RD_GO] && host_wdata[BIT_TMODE];
        cmd.wr_go    = ctrl_wr && host_wdata[BIT_WR_GO] && host_wdata[BIT_TMODE];
        cmd.src_slot = ctrl_d.src_slot;
        cmd.dst_slot = ctrl_d.dst_slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            stage_lo_q <= '0;
            stage_hi_q <= '0;
        end else begin
            if (ctrl_wr)                 ctrl_q     <= ctrl_d;
            if (host_we && sel_stage_lo) stage_lo_q <= host_wdata;
            if (host_we && sel_stage_hi) stage_hi_q <= host_wdata;
        end
    end

endmodule

// File: rtl/tbr_bank.sv
module tbr_bank
    import tbr_pkg::*;
#(
    parameter int IMPL_COUNT = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_go,
    input  logic [SLOT_AW-1:0]    dst_slot,
    input  logic [SLOT_MAX_W-1:0] wr_word,
    input  logic [SLOT_AW-1:0]    src_slot,
    output logic [SLOT_MAX_W-1:0] rd_word
);

    logic [SLOT_MAX_W-1:0] slot_val  [SLOT_COUNT];
    logic [SLOT_MAX_W-1:0] slot_mask [SLOT_COUNT];

    for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_slot
        localparam int W = slot_width(i, IMPL_COUNT);
        assign slot_mask[i] = width_mask(W);
        if (W > 0) begin : g_present
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_go && dst_slot == SLOT_AW'(i)) begin
                    q <= wr_word[W-1:0];
                end
            end
            assign slot_val[i] = SLOT_MAX_W'(q);
        end else begin : g_absent
            assign slot_val[i] = '0;
        end
    end

    // A write in the same cycle is forwarded so the read sees it.
    always_comb begin
        if (wr_go && dst_slot == src_slot) begin
            rd_word = wr_word & slot_mask[src_slot];
        end else begin
            rd_word = slot_val[src_slot];
        end
    end

endmodule

// File: rtl/tbr_readback.sv
module tbr_readback
    import tbr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_go,
    input  logic [SLOT_MAX_W-1:0] rd_word,
    output logic [HDATA_W-1:0]    rb_lo_q,
    output logic [HDATA_W-1:0]    rb_hi_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_lo_q <= '0;
            rb_hi_q <= '0;
        end else if (rd_go) begin
            rb_lo_q <= rd_word[HDATA_W-1:0];
            rb_hi_q <= rd_word[SLOT_MAX_W-1:HDATA_W];
        end
    end

endmodule

// File: rtl/test_reg_bridge.sv
module test_reg_bridge
    import tbr_pkg::*;
#(
    parameter int IMPL_COUNT  = 24,
    parameter int CTRL_ADDR   = 20,
    parameter int RB_LO_ADDR  = 21,
    parameter int RB_HI_ADDR  = 22,
    parameter int STG_LO_ADDR = 23,
    parameter int STG_HI_ADDR = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [4:0]         host_addr,
    input  logic               host_we,
    input  logic [15:0]        host_wdata,
    output logic [15:0]        host_rdata
);

    ctrl_t                 ctrl_q;
    cmd_t                  cmd;
    logic [HDATA_W-1:0]    stage_lo_q;
    logic [HDATA_W-1:0]    stage_hi_q;
    logic [HDATA_W-1:0]    rb_lo_q;
    logic [HDATA_W-1:0]    rb_hi_q;
    logic [SLOT_MAX_W-1:0] rd_word;
    logic                  sel_ctrl;
    logic                  sel_stage_lo;
    logic                  sel_stage_hi;

    assign sel_ctrl     = host_addr == HADDR_W'(CTRL_ADDR);
    assign sel_stage_lo = host_addr == HADDR_W'(STG_LO_ADDR);
    assign sel_stage_hi = host_addr == HADDR_W'(STG_HI_ADDR);

    tbr_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .host_we      (host_we),
        .sel_ctrl     (sel_ctrl),
        .sel_stage_lo (sel_stage_lo),
        .sel_stage_hi (sel_stage_hi),
        .host_wdata   (host_wdata),
        .ctrl_q       (ctrl_q),
        .cmd          (cmd),
        .stage_lo_q   (stage_lo_q),
        .stage_hi_q   (stage_hi_q)
    );

    tbr_bank #(.IMPL_COUNT(IMPL_COUNT)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_go    (cmd.wr_go),
        .dst_slot (cmd.dst_slot),
        .wr_word  ({stage_hi_q, stage_lo_q}),
        .src_slot (cmd.src_slot),
        .rd_word  (rd_word)
    );

    tbr_readback u_rb (
        .clk     (clk),
        .rst     (rst),
        .rd_go   (cmd.rd_go),
        .rd_word (rd_word),
        .rb_lo_q (rb_lo_q),
        .rb_hi_q (rb_hi_q)
    );

    always_comb begin
        host_rdata = '0;
        if (host_addr == HADDR_W'(CTRL_ADDR)) begin
            host_rdata = {5'b0, ctrl_q.tmode, ctrl_q.src_slot, ctrl_q.dst_slot};
        end else if (host_addr == HADDR_W'(RB_LO_ADDR)) begin
            host_rdata = rb_lo_q;
        end else if (host_addr == HADDR_W'(RB_HI_ADDR)) begin
            host_rdata = rb_hi_q;
        end else if (host_addr == HADDR_W'(STG_LO_ADDR)) begin
            host_rdata = stage_lo_q;
        end else if (host_addr == HADDR_W'(STG_HI_ADDR)) begin
            host_rdata = stage_hi_q;
        end
    end

endmodule

// File: rtl/tbr_checks.sv
module tbr_checks
    import tbr_pkg::*;
#(
    parameter int IMPL_COUNT = 24,
    parameter int CTRL_ADDR  = 20,
    parameter int RB_LO_ADDR = 21,
    parameter int RB_HI_ADDR = 22
) (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  host_addr,
    input logic        host_we,
    input logic [15:0] host_wdata,
    input logic [15:0] host_rdata,
    input logic [15:0] rb_lo_q,
    input logic [15:0] rb_hi_q
);

    logic ctrl_wr;
    logic rd_cmd;
    assign ctrl_wr = host_we && host_addr == 5'(CTRL_ADDR);
    assign rd_cmd  = ctrl_wr && host_wdata[15] && host_wdata[10];

    p_ctrl_high_bits_zero_r1: assert property (@(posedge clk) disable iff (rst)
        host_addr == 5'(CTRL_ADDR) |-> host_rdata[15:11] == 5'b0);

    p_narrow_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && slot_width(int'(host_wdata[9:5]), IMPL_COUNT) <= 16)
        |=> rb_hi_q == 16'h0);

    p_tmode_off_no_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !host_wdata[10]) |=> ($stable(rb_lo_q) && $stable(rb_hi_q)));

    p_absent_slot_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && int'(host_wdata[9:5]) >= IMPL_COUNT)
        |=> (rb_lo_q == 16'h0 && rb_hi_q == 16'h0));

    p_readback_readonly_r8: assert property (@(posedge clk) disable iff (rst)
        (host_we && (host_addr == 5'(RB_LO_ADDR) || host_addr == 5'(RB_HI_ADDR)))
        |=> ($stable(rb_lo_q) && $stable(rb_hi_q)));

    p_reset_clears_r8: assert property (@(posedge clk)
        $past(rst) |-> (rb_lo_q == 16'h0 && rb_hi_q == 16'h0));

endmodule

bind test_reg_bridge tbr_checks #(
    .IMPL_COUNT (IMPL_COUNT),
    .CTRL_ADDR  (CTRL_ADDR),
    .RB_LO_ADDR (RB_LO_ADDR),
    .RB_HI_ADDR (RB_HI_ADDR)
) u_checks (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .rb_lo_q    (rb_lo_q),
    .rb_hi_q    (rb_hi_q)
);

// File: tb/test_reg_bridge_tb.sv
module test_reg_bridge_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  host_addr = '0;
    logic        host_we = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    test_reg_bridge u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    // Behavioural reference state
    logic [31:0] m_slot [32];
    bit          m_tm;
    logic [4:0]  m_src, m_dst;
    logic [15:0] m_slo, m_shi, m_rlo, m_rhi;

    function automatic int w_of(input int a);
        return (a < 24) ? ((11 * a + 4) % 32) + 1 : 0;
    endfunction

    function automatic logic [31:0] trunc(input logic [31:0] v, input int w);
        longint m;
        m = (longint'(1) << w) - 1;
        return v & m[31:0];
    endfunction

    task automatic m_reset();
        foreach (m_slot[i]) m_slot[i] = '0;
        m_tm = 0; m_src = '0; m_dst = '0;
        m_slo = '0; m_shi = '0; m_rlo = '0; m_rhi = '0;
    endtask

    function automatic logic [15:0] m_read(input int a);
        case (a)
            20: return {5'b0, m_tm, m_src, m_dst};
            21: return m_rlo;
            22: return m_rhi;
            23: return m_slo;
            24: return m_shi;
            default: return 16'h0;
        endcase
    endfunction

    task automatic m_step(input int a, input bit we, input logic [15:0] d);
        if (!we) return;
        case (a)
            20: begin
                m_tm = d[10]; m_src = d[9:5]; m_dst = d[4:0];
                if (d[10] && d[14] && w_of(int'(d[4:0])) > 0)
                    m_slot[d[4:0]] = trunc({m_shi, m_slo}, w_of(int'(d[4:0])));
                if (d[10] && d[15]) begin
                    m_rlo = m_slot[d[9:5]][15:0];
                    m_rhi = m_slot[d[9:5]][31:16];
                end
            end
            23: m_slo = d;
            24: m_shi = d;
            default: ;
        endcase
    endtask

    task automatic op(input int a, input bit we, input logic [15:0] d, input string tag);
        logic [15:0] exp;
        @(negedge clk);
        host_addr = 5'(a); host_we = we; host_wdata = d;
        #1;
        if (!rst) begin
            exp = m_read(a);
            n_cmp++;
            if (host_rdata !== exp) begin
                n_bad++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, host_rdata, exp);
            end
        end
        @(posedge clk);
        if (rst) m_reset(); else m_step(a, we, d);
    endtask

    function automatic logic [15:0] ctl(bit rd, bit wr, bit tm, int src, int dst);
        return {rd, wr, 3'b000, tm, 5'(src), 5'(dst)};
    endfunction

    initial begin
        m_reset();
        rst = 1'b1;
        repeat (3) op(0, 0, 16'h0, "R8");
        rst = 1'b0;
        // R8: state after reset
        for (int a = 18; a <= 26; a++) op(a, 0, 16'h0, "R8");

        // R4, R2, R3, R7, R9: every slot, write then read
        for (int s = 0; s < 32; s++) begin
            op(23, 1, 16'($urandom), "R4");
            op(24, 1, 16'($urandom), "R4");
            op(23, 0, 16'h0, "R4");
            op(24, 0, 16'h0, "R4");
            op(20, 1, ctl(0, 1, 1, 0, s), "R4");
            op(20, 1, ctl(1, 0, 1, s, 0), "R2");
            op(21, 0, 16'h0, "R2");
            op(22, 0, 16'h0, (w_of(s) == 0) ? "R7" : "R3");
            op(20, 0, 16'h0, "R1");
        end

        // R5: commands with test mode off
        for (int s = 0; s < 24; s += 5) begin
            op(23, 1, 16'hA5C3, "R5");
            op(24, 1, 16'h3C5A, "R5");
            op(20, 1, ctl(1, 1, 0, s, s), "R5");
            op(20, 0, 16'h0, "R5");
            op(21, 0, 16'h0, "R5");
            op(22, 0, 16'h0, "R5");
            op(20, 1, ctl(1, 0, 1, s, 0), "R5");
            op(21, 0, 16'h0, "R5");
            op(22, 0, 16'h0, "R5");
        end

        // R6: combined command, same slot (wide 17, 4; narrow 20, 1)
        foreach (m_slot[k]) if (k == 1 || k == 4 || k == 17 || k == 20 || k == 30) begin
            op(23, 1, 16'($urandom), "R6");
            op(24, 1, 16'($urandom), "R6");
            op(20, 1, ctl(1, 1, 1, k, k), "R6");
            op(21, 0, 16'h0, "R6");
            op(22, 0, 16'h0, "R6");
        end

        // R8: read-back words are read-only
        op(21, 1, 16'hFFFF, "R8");
        op(21, 0, 16'h0, "R8");
        op(22, 1, 16'hFFFF, "R8");
        op(22, 0, 16'h0, "R8");
        op(19, 1, 16'hFFFF, "R8");
        op(19, 0, 16'h0, "R8");

        // R1: reserved bits written as ones read back as zero
        op(20, 1, 16'h3BFF & ~16'h0400, "R1");
        op(20, 0, 16'h0, "R1");

        // Mixed traffic
        for (int i = 0; i < 600; i++) begin
            int a;
            a = 18 + int'($urandom_range(0, 7));
            op(a, 1'($urandom), 16'($urandom), "R2");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule